// File: doc/BRIEF.md
# Reference Divider, Phase Comparator and Test-Mode Control

This block is the digital timing core of a tuning synthesizer. It runs on one system clock. Two strobe inputs stand in for the edges of the crystal reference and of the prescaled oscillator. The reference strobes feed a divider whose ratio is set by two select bits. The prescaled strobes feed a 15-bit programmable divider. One-cycle pulses from both dividers drive a phase/frequency detector, which issues pump-up and pump-down requests. A lock detector watches the width of those requests.

A three-bit test code sits between the detector and the pins. It can pass the detector through, switch the pump off, force a steady sink or source, or swap the lock indication for the reference pulse train or the halved divider output. A tuning controller sets the divider word, the select bits and the test code. The analog pump and the prescaler are outside this block.

Top module: `tsyn_core`

## Requirements
- R1: With `ratio_hi_i`=0 the reference divider produces one pulse every 640 reference strobes, whatever `ratio_lo_i` is.
- R2: With `ratio_hi_i`=1 the reference ratio is 1024 when `ratio_lo_i`=0 and 512 when `ratio_lo_i`=1.
- R3: Any change of {`ratio_hi_i`,`ratio_lo_i`} after reset restarts the reference count from zero, so the next reference pulse comes a full new ratio after the change.
- R4: The programmable divider produces one pulse every N prescaled strobes, where N = `div_word_i`. Values 0 and 1 both divide by 1.
- R5: The detector raises up on a reference pulse and down on a divider pulse. It clears both once both have been seen, so up and down are never high together and coincident pulses give no request.
- R6: `lock_o` is 0 after reset. In test codes 000, 001, 010, 011, 110 and 111 it goes to 1 after 4 consecutive comparison periods in which no request lasted more than one clock.
- R7: A request lasting two or more clocks clears the lock indication at once.
- R8: Test codes 010 and 011 drive `pump_up_o`, `pump_dn_o` and `pump_en_o` to 0.
- R9: Test code 110 gives `pump_dn_o`=1, `pump_up_o`=0 and `pump_en_o`=1. Test code 111 gives `pump_up_o`=1, `pump_dn_o`=0 and `pump_en_o`=1.
- R10: Test code 100 places the one-clock reference pulse on `lock_o`, giving one rising edge per reference period.
- R11: Test code 101 places the divider output halved on `lock_o`, so the pin toggles on every divider pulse.
- R12: Test code 000 behaves as code 001: detector requests drive the pump, `pump_en_o`=1, and `lock_o` shows the lock status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One strobe per reference clock edge |
| pre_tick_i | input | 1 | One strobe per prescaled clock edge |
| div_word_i | input | 15 | Programmable divide ratio N |
| ratio_lo_i | input | 1 | Reference ratio select, low bit |
| ratio_hi_i | input | 1 | Reference ratio select, high bit |
| test_i | input | 3 | Test code |
| pump_up_o | output | 1 | Pump source request |
| pump_dn_o | output | 1 | Pump sink request |
| pump_en_o | output | 1 | Pump enable |
| lock_o | output | 1 | Lock status or test signal |

## Verification
The assertions take the strobes to be synchronous to `clk_i`, sampled once per clock, and they assume that ratio and divider settings stay fixed while reset is asserted. The count bound on the reference divider is relaxed for the one cycle in which the ratio changes. The stimulus sets every setting inside reset or at a falling clock edge and holds both strobes high from reset release. Both dividers therefore start from zero together, and a matched ratio gives pulses that coincide exactly.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;
  localparam int DIV_W = 15;

  typedef enum logic [2:0] {
    TM_UNDEF = 3'b000,
    TM_NORM  = 3'b001,
    TM_OFF0  = 3'b010,
    TM_OFF1  = 3'b011,
    TM_REFO  = 3'b100,
    TM_DIVO  = 3'b101,
    TM_SINK  = 3'b110,
    TM_SRC   = 3'b111
  } test_e;
endpackage

// File: rtl/tsyn_ref_div.sv
module tsyn_ref_div #(
  parameter int CNT_W  = 11,
  parameter int R_BASE = 640,
  parameter int R_LONG = 1024,
  parameter int R_SHRT = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sel_lo_i,
  input  logic sel_hi_i,
  output logic pls_o
);
  localparam logic [CNT_W-1:0] RB = CNT_W'(R_BASE);
  localparam logic [CNT_W-1:0] RL = CNT_W'(R_LONG);
  localparam logic [CNT_W-1:0] RS = CNT_W'(R_SHRT);

  logic [CNT_W-1:0] cnt_q, ratio;
  logic [1:0]       sel_q;
  logic             vld_q, chg;

  always_comb begin
    if (!sel_hi_i)     ratio = RB;
    else if (sel_lo_i) ratio = RS;
    else               ratio = RL;
  end

  assign chg = vld_q && (sel_q != {sel_hi_i, sel_lo_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pls_o <= 1'b0;
      sel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sel_q <= {sel_hi_i, sel_lo_i};
      vld_q <= 1'b1;
      pls_o <= 1'b0;
      if (chg) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q >= ratio - 1'b1) begin
          cnt_q <= '0;
          pls_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_ref_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg |-> (cnt_q < ratio))
    else $error("reference count out of range");

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (cnt_q == '0) && !pls_o)
    else $error("ratio change did not restart count");
endmodule

// File: rtl/tsyn_prog_div.sv
module tsyn_prog_div #(
  parameter int DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] n_i,
  output logic             pls_o,
  output logic             half_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             term;

  assign term = ({1'b0, cnt_q} + 1'b1) >= {1'b0, n_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pls_o  <= 1'b0;
      half_o <= 1'b0;
    end else begin
      pls_o <= 1'b0;
      if (tick_i) begin
        if (term) begin
          cnt_q  <= '0;
          pls_o  <= 1'b1;
          half_o <= ~half_o;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_half_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_o != $past(half_o)) |-> pls_o)
    else $error("half rate output moved without a divider pulse");
endmodule

// File: rtl/tsyn_pfd_lock.sv
module tsyn_pfd_lock #(
  parameter int LOCK_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_pls_i,
  input  logic div_pls_i,
  output logic up_o,
  output logic dn_o,
  output logic lock_o
);
  localparam int LW = $clog2(LOCK_N + 1);

  logic          up_n, dn_n, act_q, long_req, dirty_q;
  logic [LW-1:0] good_q;

  assign up_n = up_o | ref_pls_i;
  assign dn_n = dn_o | div_pls_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else if (up_n && dn_n) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_n;
      dn_o <= dn_n;
    end
  end

  // a request still high on its second cycle is too long
  assign long_req = (up_o | dn_o) & act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      dirty_q <= 1'b0;
      good_q  <= '0;
    end else begin
      act_q <= up_o | dn_o;
      if (long_req) begin
        good_q  <= '0;
        dirty_q <= 1'b1;
      end else if (ref_pls_i) begin
        dirty_q <= 1'b0;
        if (dirty_q)                   good_q <= '0;
        else if (good_q != LW'(LOCK_N)) good_q <= good_q + 1'b1;
      end
    end
  end

  assign lock_o = (good_q == LW'(LOCK_N));

  p_pfd_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o))
    else $error("up and down both active");

  p_lock_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ref_pls_i))
    else $error("lock rose outside a comparison edge");

  p_lock_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_req |=> !lock_o)
    else $error("lock held through a long request");
endmodule

// File: rtl/tsyn_core.sv
module tsyn_core
  import tsyn_pkg::*;
#(
  parameter int REF_W  = 11,
  parameter int LOCK_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             pre_tick_i,
  input  logic [DIV_W-1:0] div_word_i,
  input  logic             ratio_lo_i,
  input  logic             ratio_hi_i,
  input  logic [2:0]       test_i,
  output logic             pump_up_o,
  output logic             pump_dn_o,
  output logic             pump_en_o,
  output logic             lock_o
);
  logic ref_pls, div_pls, div_half, pfd_up, pfd_dn, lock_st;

  tsyn_ref_div #(.CNT_W(REF_W)) u_ref (
    .clk_i, .rst_ni, .tick_i(ref_tick_i),
    .sel_lo_i(ratio_lo_i), .sel_hi_i(ratio_hi_i), .pls_o(ref_pls)
  );

  tsyn_prog_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .tick_i(pre_tick_i), .n_i(div_word_i),
    .pls_o(div_pls), .half_o(div_half)
  );

  tsyn_pfd_lock #(.LOCK_N(LOCK_N)) u_pfd (
    .clk_i, .rst_ni, .ref_pls_i(ref_pls), .div_pls_i(div_pls),
    .up_o(pfd_up), .dn_o(pfd_dn), .lock_o(lock_st)
  );

  always_comb begin
    pump_up_o = pfd_up;
    pump_dn_o = pfd_dn;
    pump_en_o = 1'b1;
    lock_o    = lock_st;
    case (test_e'(test_i))
      TM_OFF0, TM_OFF1: begin
        pump_up_o = 1'b0;
        pump_dn_o = 1'b0;
        pump_en_o = 1'b0;
      end
      TM_SINK: begin
        pump_up_o = 1'b0;
        pump_dn_o = 1'b1;
      end
      TM_SRC: begin
        pump_up_o = 1'b1;
        pump_dn_o = 1'b0;
      end
      TM_REFO: lock_o = ref_pls;
      TM_DIVO: lock_o = div_half;
      default: ;
    endcase
  end

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i[2:1] == 2'b01) |-> !(pump_up_o | pump_dn_o | pump_en_o))
    else $error("pump active in off mode");
endmodule

// File: tb/tsyn_core_test.sv
`timescale 1ns/1ps
module tsyn_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, pre_tick = 1'b0;
  logic [14:0] div_word = 15'd512;
  logic        r_lo = 1'b0, r_hi = 1'b0;
  logic [2:0]  test = 3'b001;
  logic        up, dn, en, lock;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tsyn_core uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pre_tick_i(pre_tick),
    .div_word_i(div_word), .ratio_lo_i(r_lo), .ratio_hi_i(r_hi), .test_i(test),
    .pump_up_o(up), .pump_dn_o(dn), .pump_en_o(en), .lock_o(lock)
  );

  // columns: test code, {hi,lo}, divider word, expected period in clocks
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{4, 0, 7,   640},   // R1
    '{4, 1, 7,   640},   // R1
    '{4, 2, 7,   1024},  // R2
    '{4, 3, 7,   512},   // R2
    '{5, 3, 3,   3},     // R4 R11
    '{5, 3, 100, 100},   // R4 R11
    '{5, 3, 1,   1},     // R4
    '{5, 3, 0,   1}      // R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int tc, input int rs, input int nw);
    @(negedge clk);
    rst_n = 1'b0;
    ref_tick = 1'b0; pre_tick = 1'b0;
    test = 3'(tc); r_hi = rs[1]; r_lo = rs[0]; div_word = 15'(nw);
    cyc(2);
    rst_n = 1'b1; ref_tick = 1'b1; pre_tick = 1'b1;
  endtask

  // clocks from one marker event on lock to the next; rise_only picks rising edges
  task automatic period(input bit rise_only, output int p);
    logic prev;
    int   k;
    p = -1;
    prev = lock;
    for (k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (rise_only ? (lock && !prev) : (lock != prev)) break;
      prev = lock;
    end
    prev = lock;
    for (int j = 1; j < 3000; j++) begin
      @(negedge clk);
      if (rise_only ? (lock && !prev) : (lock != prev)) begin p = j; break; end
      prev = lock;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p, act, t0;

    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][0], VEC[i][1], VEC[i][2]);
      period(VEC[i][0] == 4, p);
      chk($sformatf("R1/R2/R4/R10/R11 period row %0d", i), p, VEC[i][3]);
    end

    // reset state and lock acquisition, matched ratio 512
    do_reset(1, 3, 512);
    @(negedge clk);
    chk("R6 lock after reset", lock, 0);
    chk("R6 pump idle after reset", up | dn, 0);
    act = 0;
    for (int k = 0; k < 3 * 512 + 9; k++) begin
      @(negedge clk);
      act |= (up | dn);
    end
    chk("R5 coincident pulses give no request", act, 0);
    chk("R6 lock low after 3 periods", lock, 0);
    cyc(2 * 512);
    chk("R6 lock high after 4 clean periods", lock, 1);

    test = 3'b000; @(negedge clk);
    chk("R12 code 000 lock", lock, 1);
    chk("R12 code 000 enable", en, 1);
    chk("R12 code 000 pump idle", up | dn, 0);
    test = 3'b010; @(negedge clk);
    chk("R8 code 010 pump", {up, dn, en}, 0);
    chk("R6 code 010 lock status", lock, 1);
    test = 3'b011; @(negedge clk);
    chk("R8 code 011 pump", {up, dn, en}, 0);
    test = 3'b110; @(negedge clk);
    chk("R9 code 110 up/dn/en", {up, dn, en}, 3'b011);
    test = 3'b111; @(negedge clk);
    chk("R9 code 111 up/dn/en", {up, dn, en}, 3'b101);
    test = 3'b001;
    div_word = 15'd520;
    cyc(600);
    chk("R7 lock lost on long request", lock, 0);

    // divider fast: down request held from divider pulse to next reference pulse
    do_reset(1, 3, 256);
    cyc(400);
    chk("R5 down held", {up, dn}, 2'b01);
    cyc(130);
    chk("R5 cleared after both", {up, dn}, 2'b00);

    // ratio change restarts reference count
    do_reset(4, 3, 7);
    period(1'b1, p);
    cyc(100);
    r_lo = 1'b0;
    t0 = 0;
    for (int k = 1; k < 3000; k++) begin
      @(negedge clk);
      if (lock) begin t0 = k; break; end
    end
    chk("R3 restart in window", (t0 >= 1020 && t0 <= 1030) ? 1 : 0, 1);
    if (!(t0 >= 1020 && t0 <= 1030)) $display("  R3 observed gap %0d", t0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule